// File: doc/BRIEF.md
# Program-Counter Span Timer

This peripheral measures how many clock cycles a stretch of code takes. It watches the processor's 32-bit program counter. When the counter equals a programmed start address, the unit begins counting clocks. When it later equals a programmed end address, counting stops. The result is then copied into a holding register that software reads over a small 16-bit register bus.

Each address is loaded as two 16-bit halves. All run/stop control is a synchronous flag on the main clock, so no comparator output ever drives a clock. After a stop the unit runs a fixed two-step sequence on its own. It latches the result on the first cycle and zeroes the running count on the second. It is then ready to measure again. A done flag shows that a fresh result is waiting. Software clears that flag by rewriting the low half of the start address.

Top module: `pc_span_timer`

## Requirements
- R1: After reset, every readable register returns 0, `span_count` is 0, `span_done` is 0 and the unit is idle.
- R2: Register offsets on `reg_sel` are: 0 start address bits 15:0, 1 start address bits 31:16, 2 end address bits 15:0, 3 end address bits 31:16. Each of these reads back what was last written. Offset 4 reads the latched count. Offset 5 reads status: bit 0 is done, bit 1 is running, and the other bits are 0. Writes to offsets 4 to 7 change nothing, and offsets 6 and 7 read 0.
- R3: Suppose the start address is seen on `pc` at clock edge S while idle, and the end address is next seen at edge E while running. The measured count is then E−S.
- R4: A start-address match while the unit is running has no effect on the count or on the running state.
- R5: An end-address match while the unit is not running has no effect: the latched count and the done flag do not change.
- R6: The edge after the stop edge copies the count into the holding register (`span_count`, offset 4) and sets done.
- R7: The edge after the copy clears the running count. A start match during the copy edge or the clear edge is ignored, and a start match on any later edge is accepted.
- R8: While the unit is running, the count saturates at 2^CNT_W−1 instead of wrapping.
- R9: Writing offset 0 clears done, and writing any other offset leaves done unchanged. If that write happens on the copy edge, done is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | 32 | Processor program counter being watched |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_sel` (combinational) |
| span_count | output | 16 | Latched cycle count |
| span_done | output | 1 | A new count has been latched |

## Verification
The bench builds the block with an 8-bit count (CNT_W = 8) and keeps the 16-bit data width. This brings saturation within a few hundred cycles, so the clamp and the hold after it are checked directly instead of only on paper. A long random run then moves the program counter over the start address, the end address and unrelated values. That run places start and end matches at every phase of the run, copy and clear sequence, including a stop right after a start.

// File: rtl/pc_span_timer.sv
module pc_span_timer #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*DATA_W-1:0] pc,
  input  logic                reg_we,
  input  logic [SEL_W-1:0]    reg_sel,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [DATA_W-1:0]   span_count,
  output logic                span_done
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] start_lo, start_hi, end_lo, end_hi;
  logic [ADDR_W-1:0] start_addr, end_addr;
  logic [CNT_W-1:0]  cnt_q, hold_q;
  logic              run_q, latch_q, clear_q;

  assign start_addr = {start_hi, start_lo};
  assign end_addr   = {end_hi, end_lo};

  wire idle = !run_q && !latch_q && !clear_q;
  wire go   = idle && (pc == start_addr);
  wire stop = run_q && (pc == end_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_lo <= '0;
      start_hi <= '0;
      end_lo   <= '0;
      end_hi   <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_W'(0): start_lo <= reg_wdata;
        SEL_W'(1): start_hi <= reg_wdata;
        SEL_W'(2): end_lo   <= reg_wdata;
        SEL_W'(3): end_hi   <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      latch_q <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      if (go)        run_q <= 1'b1;
      else if (stop) run_q <= 1'b0;
      latch_q <= stop;
      clear_q <= latch_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clear_q)               cnt_q <= '0;
    else if (run_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      span_done <= 1'b0;
    end else begin
      if (latch_q) hold_q <= cnt_q;
      if (latch_q)                                  span_done <= 1'b1;
      else if (reg_we && reg_sel == SEL_W'(0))      span_done <= 1'b0;
    end
  end

  assign span_count = DATA_W'(hold_q);

  always_comb begin
    case (reg_sel)
      SEL_W'(0): reg_rdata = start_lo;
      SEL_W'(1): reg_rdata = start_hi;
      SEL_W'(2): reg_rdata = end_lo;
      SEL_W'(3): reg_rdata = end_hi;
      SEL_W'(4): reg_rdata = span_count;
      SEL_W'(5): reg_rdata = DATA_W'({run_q, span_done});
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pc_span_timer_chk.sv
module pc_span_timer_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*DATA_W-1:0] pc,
  input logic [2*DATA_W-1:0] end_addr,
  input logic                reg_we,
  input logic [SEL_W-1:0]    reg_sel,
  input logic                run_q,
  input logic                latch_q,
  input logic [CNT_W-1:0]    cnt_q,
  input logic [DATA_W-1:0]   span_count,
  input logic                span_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R3
  count_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> cnt_q >= $past(cnt_q));

  // R4
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && pc != end_addr) |=> run_q);

  // R5
  idle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !latch_q) |=> $stable(span_count));

  // R6
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && pc == end_addr) |=> !run_q ##1 span_done);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |=> ##1 (cnt_q == '0));

  // R8
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  // R9
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_W'(0) && !latch_q) |=> !span_done);
endmodule

bind pc_span_timer pc_span_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .end_addr(end_addr),
  .reg_we(reg_we), .reg_sel(reg_sel), .run_q(run_q), .latch_q(latch_q),
  .cnt_q(cnt_q), .span_count(span_count), .span_done(span_done)
);

// File: tb/test_pc_span_timer.sv
`timescale 1ns/1ps
module test_pc_span_timer;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam logic [CW-1:0] MAXC = {CW{1'b1}};
  localparam logic [31:0] NEUTRAL = 32'h0000_0100;
  localparam logic [31:0] SA = 32'h1234_5678;
  localparam logic [31:0] EA = 32'h1234_9ABC;

  logic clk = 0, rst_n = 0;
  logic [31:0] pc = NEUTRAL;
  logic reg_we = 0;
  logic [2:0] reg_sel = 0;
  logic [DW-1:0] reg_wdata = 0;
  logic [DW-1:0] reg_rdata, span_count;
  logic span_done;

  int n_tests = 0, n_fail = 0;

  logic [DW-1:0] m_sl, m_sh, m_el, m_eh;
  logic [CW-1:0] m_cnt, m_hold;
  logic m_run, m_lat, m_clr, m_done;

  always #5 clk = ~clk;

  pc_span_timer #(.DATA_W(DW), .CNT_W(CW), .SEL_W(3)) i_pc_span_timer (
    .clk(clk), .rst_n(rst_n), .pc(pc), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .span_count(span_count),
    .span_done(span_done));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] sat_inc(logic [CW-1:0] v);
    return (v == MAXC) ? v : v + 1'b1;
  endfunction

  task automatic tick();
    logic idle, hs, he, n_run;
    logic [CW-1:0] n_cnt, n_hold;
    logic n_lat, n_clr, n_done;
    hs = (pc == {m_sh, m_sl});
    he = (pc == {m_eh, m_el});
    idle = !m_run && !m_lat && !m_clr;
    n_cnt = m_clr ? '0 : (m_run ? sat_inc(m_cnt) : m_cnt);
    n_run = (idle && hs) ? 1'b1 : ((m_run && he) ? 1'b0 : m_run);
    n_lat = m_run && he;
    n_clr = m_lat;
    n_hold = m_lat ? m_cnt : m_hold;
    n_done = m_lat ? 1'b1 : ((reg_we && reg_sel == 0) ? 1'b0 : m_done);
    if (reg_we) case (reg_sel)
      3'd0: m_sl = reg_wdata;
      3'd1: m_sh = reg_wdata;
      3'd2: m_el = reg_wdata;
      3'd3: m_eh = reg_wdata;
      default: ;
    endcase
    @(posedge clk);
    m_cnt = n_cnt; m_run = n_run; m_lat = n_lat; m_clr = n_clr;
    m_hold = n_hold; m_done = n_done;
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] s, logic [DW-1:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(logic [2:0] s, output logic [DW-1:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic step_pc(logic [31:0] p, int n);
    pc = p;
    for (int i = 0; i < n; i++) tick();
    pc = NEUTRAL;
  endtask

  task automatic cmp_model(string tag);
    logic [DW-1:0] d;
    chk({tag, " count"}, span_count, 32'(m_hold));
    chk({tag, " done"}, span_done, m_done);
    rd(3'd5, d);
    chk({tag, " status"}, d, {m_run, m_done});
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    m_sl = 0; m_sh = 0; m_el = 0; m_eh = 0;
    m_cnt = 0; m_hold = 0; m_run = 0; m_lat = 0; m_clr = 0; m_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int s = 0; s < 8; s++) begin rd(3'(s), d); chk("R1 reg", d, 0); end
    chk("R1 count", span_count, 0);
    chk("R1 done", span_done, 0);

    // R2 register map and readback
    wr(3'd0, SA[15:0]); wr(3'd1, SA[31:16]); wr(3'd2, EA[15:0]); wr(3'd3, EA[31:16]);
    rd(3'd0, d); chk("R2 start lo", d, SA[15:0]);
    rd(3'd1, d); chk("R2 start hi", d, SA[31:16]);
    rd(3'd2, d); chk("R2 end lo", d, EA[15:0]);
    rd(3'd3, d); chk("R2 end hi", d, EA[31:16]);
    wr(3'd4, 16'hBEEF); wr(3'd5, 16'hFFFF); wr(3'd6, 16'h1111);
    rd(3'd4, d); chk("R2 count ro", d, 0);
    rd(3'd5, d); chk("R2 status ro", d, 0);
    rd(3'd6, d); chk("R2 off6", d, 0);
    rd(3'd0, d); chk("R2 start kept", d, SA[15:0]);

    // R5 end match while idle
    step_pc(EA, 3);
    chk("R5 count", span_count, 0);
    chk("R5 done", span_done, 0);

    // R3 basic span, R6 latch timing
    step_pc(SA, 1);
    rd(3'd5, d); chk("R3 running", d, 2);
    step_pc(NEUTRAL, 10);
    step_pc(EA, 1);
    chk("R6 not yet", span_count, 0);
    rd(3'd5, d); chk("R6 stopped", d, 0);
    tick();
    chk("R6 R3 count", span_count, 11);
    chk("R6 done", span_done, 1);
    rd(3'd4, d); chk("R6 reg count", d, 11);

    // R7 start on clear edge ignored, later accepted
    step_pc(SA, 1);
    step_pc(NEUTRAL, 4);
    rd(3'd5, d); chk("R7 ignored on clear", d, 1);
    step_pc(SA, 1);
    rd(3'd5, d); chk("R7 rearmed", d, 3);

    // R4 restart while running ignored
    step_pc(NEUTRAL, 2);
    step_pc(SA, 2);
    step_pc(NEUTRAL, 1);
    step_pc(EA, 1);
    tick();
    chk("R4 R7 count", span_count, 6);

    // R9 done clearing rules
    wr(3'd1, SA[31:16]);
    chk("R9 other write keeps", span_done, 1);
    wr(3'd0, SA[15:0]);
    chk("R9 clear", span_done, 0);
    step_pc(EA, 1);
    chk("R5 idle end keeps done", span_done, 0);
    tick(); tick();
    step_pc(SA, 1); step_pc(NEUTRAL, 1); step_pc(EA, 1);
    wr(3'd0, SA[15:0]);
    chk("R9 set wins", span_done, 1);
    chk("R3 short count", span_count, 2);

    // R8 saturation
    tick(); tick();
    step_pc(SA, 1);
    step_pc(NEUTRAL, 300);
    step_pc(EA, 1);
    tick();
    chk("R8 saturate", span_count, 32'(MAXC));
    tick(); tick();

    // R3 R4 R5 R6 R7 R9 random against bench model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 10) pc = SA;
      else if (r < 20) pc = EA;
      else if (r < 25) pc = $urandom;
      else pc = NEUTRAL;
      if ($urandom_range(0, 49) == 0) begin
        reg_we = 1;
        reg_sel = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'd5;
        reg_wdata = (reg_sel == 3'd0) ? SA[15:0] : 16'h5A5A;
      end
      tick();
      reg_we = 0;
      if (i % 4 == 0) cmp_model("R3 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule